// File: doc/BRIEF.md
# Permuted-Interleave DRAM Bank Mapper

This block takes a physical request address and turns it into the bank, row and column coordinates of a banked DRAM. The bank is not taken straight from the address. The plain bank field is XOR-folded with the low bits of the L2 cache tag. Addresses that collide in one cache set, but carry different tags, therefore land in different banks. All addresses inside one DRAM page still share a bank.

For every bank the block holds a small state machine with two states, BK_CLOSED (precharged) and BK_OPEN (a row is latched), and it keeps the number of the latched row. Each request is classified against that state as one of three cases: a row-buffer hit, an access to a precharged bank, or a conflict with another open row. One cycle later the block returns the coordinates, the class and a latency figure in clock cycles. The transitions of each bank are:
- CLOSED→OPEN on an access.
- OPEN→OPEN on an access, which replaces the latched row.
- OPEN→CLOSED on a precharge command with no access to that bank in the same cycle.
- CLOSED→CLOSED on a precharge, or when the bank is not addressed.

Top module: `dram_bank_mapper`

## Requirements
- R1: With T = BLK_OFF_BITS + SET_BITS, the reported bank equals addr[PAGE_BITS+BANK_BITS-1:PAGE_BITS] XOR addr[T+BANK_BITS-1:T]. The row equals addr[ADDR_W-1:PAGE_BITS+BANK_BITS] and the column equals addr[PAGE_BITS-1:0].
- R2: rsp_valid is high in the cycle after a cycle with req_valid high, and low after a cycle without one.
- R3: Two addresses that differ only in their page-offset bits map to the same bank.
- R4: Two addresses with equal bank field and set index, whose tag low BANK_BITS bits differ, map to different banks.
- R5: rsp_class encodes 0 for a row hit, 1 for a precharged bank, and 2 for a different open row. rsp_latency is LAT_HIT (4), LAT_CLOSED (8) or LAT_CONFLICT (14) to match.
- R6: After an access, the addressed bank is open with the accessed row, so a repeat access to that row is class 0.
- R7: A precharge closes its bank, so the next access there is class 1. A precharge of a bank that is already closed has no effect.
- R8: After reset every bank is closed, so the first access to any bank is class 1.
- R9: When an access and a precharge target the same bank in one cycle, the access is classified against the prior state and the bank ends open with the new row.
- R10: Over any aligned run of 2^(2·BANK_BITS) consecutive pages, every bank receives the same number of pages.
- R11: A parameter set in which the tag's low BANK_BITS bits overlap the bank field, or run past the address, is refused at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Physical request address |
| pre_valid | input | 1 | Precharge command present |
| pre_bank | input | BANK_BITS | Bank to precharge |
| rsp_valid | output | 1 | Response present |
| rsp_bank | output | BANK_BITS | Permuted bank index |
| rsp_row | output | ADDR_W-PAGE_BITS-BANK_BITS | Row number |
| rsp_col | output | PAGE_BITS | Column (page offset) |
| rsp_class | output | 2 | Access class (0 hit, 1 closed, 2 conflict) |
| rsp_latency | output | LAT_W | Access latency in cycles |

## Verification
The bench builds the defaults: a 32-bit address, 32 banks, 2 KB pages, and a tag that starts at bit 16 (64-byte blocks, 1024 sets). With these values the tag's low five bits sit directly above the bank field. A sweep of 1024 consecutive pages then covers every pairing of bank field and tag bits, which shows that the permutation is uniform. Random traffic uses only a few rows, so hits, precharged accesses and conflicts all occur often, and random precharges sometimes collide with an access to the same bank.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
    typedef enum logic [1:0] {
        ACC_HIT      = 2'd0,
        ACC_CLOSED   = 2'd1,
        ACC_CONFLICT = 2'd2
    } acc_class_t;

    typedef enum logic {
        BK_CLOSED = 1'b0,
        BK_OPEN   = 1'b1
    } bank_state_t;
endpackage

// File: rtl/dbm_addr_split.sv
module dbm_addr_split #(
    parameter int ADDR_W    = 32,
    parameter int BANK_BITS = 5,
    parameter int PAGE_BITS = 11,
    parameter int TAG_LSB   = 16,
    localparam int ROW_W    = ADDR_W - PAGE_BITS - BANK_BITS
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [BANK_BITS-1:0] bank,
    output logic [ROW_W-1:0]     row,
    output logic [PAGE_BITS-1:0] col
);
    logic [BANK_BITS-1:0] field_bank;
    logic [BANK_BITS-1:0] tag_low;

    always_comb begin
        field_bank = addr[PAGE_BITS +: BANK_BITS];
        tag_low    = addr[TAG_LSB +: BANK_BITS];
        bank       = field_bank ^ tag_low;
        row        = addr[ADDR_W-1 -: ROW_W];
        col        = addr[PAGE_BITS-1:0];
    end
endmodule

// File: rtl/dbm_row_table.sv
module dbm_row_table
    import dbm_pkg::*;
#(
    parameter int BANK_BITS = 5,
    parameter int ROW_W     = 16,
    localparam int BANKS    = 1 << BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic [BANK_BITS-1:0] acc_bank,
    input  logic [ROW_W-1:0]     acc_row,
    input  logic                 pre_en,
    input  logic [BANK_BITS-1:0] pre_bank,
    output logic                 look_open,
    output logic [ROW_W-1:0]     look_row
);
    bank_state_t      state_q [BANKS];
    bank_state_t      state_d [BANKS];
    logic [ROW_W-1:0] row_q   [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit_acc;
        logic hit_pre;
        assign hit_acc = acc_en && (acc_bank == BANK_BITS'(b));
        assign hit_pre = pre_en && (pre_bank == BANK_BITS'(b));

        always_comb begin
            state_d[b] = state_q[b];
            unique case (state_q[b])
                BK_CLOSED: if (hit_acc) state_d[b] = BK_OPEN;
                BK_OPEN: begin
                    if (hit_acc)      state_d[b] = BK_OPEN;
                    else if (hit_pre) state_d[b] = BK_CLOSED;
                end
            endcase
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[b] <= BK_CLOSED;
                row_q[b]   <= '0;
            end else begin
                state_q[b] <= state_d[b];
                if (hit_acc) row_q[b] <= acc_row;
            end
        end
    end

    always_comb begin
        look_open = (state_q[acc_bank] == BK_OPEN);
        look_row  = row_q[acc_bank];
    end

    // R6: an access leaves its bank open on the accessed row
    a_r6_opens_row: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> (state_q[$past(acc_bank)] == BK_OPEN) && (row_q[$past(acc_bank)] == $past(acc_row)));

    // R7: a precharge with no access to the same bank closes it
    a_r7_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !(acc_en && acc_bank == pre_bank)) |=> (state_q[$past(pre_bank)] == BK_CLOSED));
endmodule

// File: rtl/dbm_classifier.sv
module dbm_classifier
    import dbm_pkg::*;
#(
    parameter int ROW_W        = 16,
    parameter int LAT_HIT      = 4,
    parameter int LAT_CLOSED   = 8,
    parameter int LAT_CONFLICT = 14,
    parameter int LAT_W        = 4
) (
    input  logic             is_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] req_row,
    output acc_class_t       cls,
    output logic [LAT_W-1:0] lat
);
    always_comb begin
        if (!is_open)               cls = ACC_CLOSED;
        else if (open_row == req_row) cls = ACC_HIT;
        else                        cls = ACC_CONFLICT;
    end

    always_comb begin
        unique case (cls)
            ACC_HIT:      lat = LAT_W'(LAT_HIT);
            ACC_CLOSED:   lat = LAT_W'(LAT_CLOSED);
            ACC_CONFLICT: lat = LAT_W'(LAT_CONFLICT);
            default:      lat = LAT_W'(LAT_CONFLICT);
        endcase
    end
endmodule

// File: rtl/dram_bank_mapper.sv
module dram_bank_mapper
    import dbm_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int BANK_BITS    = 5,
    parameter int PAGE_BITS    = 11,
    parameter int BLK_OFF_BITS = 6,
    parameter int SET_BITS     = 10,
    parameter int LAT_HIT      = 4,
    parameter int LAT_CLOSED   = 8,
    parameter int LAT_CONFLICT = 14,
    localparam int ROW_W   = ADDR_W - PAGE_BITS - BANK_BITS,
    localparam int TAG_LSB = BLK_OFF_BITS + SET_BITS,
    localparam int LAT_MX1 = (LAT_HIT > LAT_CLOSED) ? LAT_HIT : LAT_CLOSED,
    localparam int LAT_MAX = (LAT_MX1 > LAT_CONFLICT) ? LAT_MX1 : LAT_CONFLICT,
    localparam int LAT_W   = $clog2(LAT_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 pre_valid,
    input  logic [BANK_BITS-1:0] pre_bank,
    output logic                 rsp_valid,
    output logic [BANK_BITS-1:0] rsp_bank,
    output logic [ROW_W-1:0]     rsp_row,
    output logic [PAGE_BITS-1:0] rsp_col,
    output logic [1:0]           rsp_class,
    output logic [LAT_W-1:0]     rsp_latency
);
    // R11: tag low bits must sit above the bank field and inside the address
    if ((TAG_LSB < PAGE_BITS + BANK_BITS) || (TAG_LSB + BANK_BITS > ADDR_W)) begin : g_bad_cfg
        $error("dram_bank_mapper: tag bits overlap bank field or exceed address width");
    end

    logic [BANK_BITS-1:0] map_bank;
    logic [ROW_W-1:0]     map_row;
    logic [PAGE_BITS-1:0] map_col;
    logic                 tbl_open;
    logic [ROW_W-1:0]     tbl_row;
    acc_class_t           cls;
    logic [LAT_W-1:0]     lat;

    dbm_addr_split #(
        .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .PAGE_BITS(PAGE_BITS), .TAG_LSB(TAG_LSB)
    ) u_split (
        .addr(req_addr), .bank(map_bank), .row(map_row), .col(map_col)
    );

    dbm_row_table #(.BANK_BITS(BANK_BITS), .ROW_W(ROW_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .acc_en(req_valid), .acc_bank(map_bank), .acc_row(map_row),
        .pre_en(pre_valid), .pre_bank(pre_bank),
        .look_open(tbl_open), .look_row(tbl_row)
    );

    dbm_classifier #(
        .ROW_W(ROW_W), .LAT_HIT(LAT_HIT), .LAT_CLOSED(LAT_CLOSED),
        .LAT_CONFLICT(LAT_CONFLICT), .LAT_W(LAT_W)
    ) u_class (
        .is_open(tbl_open), .open_row(tbl_row), .req_row(map_row), .cls(cls), .lat(lat)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_bank    <= '0;
            rsp_row     <= '0;
            rsp_col     <= '0;
            rsp_class   <= '0;
            rsp_latency <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_bank    <= map_bank;
                rsp_row     <= map_row;
                rsp_col     <= map_col;
                rsp_class   <= cls;
                rsp_latency <= lat;
            end
        end
    end

    // R2: one response per request, one cycle later
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R5: class and latency agree at the port
    a_r5_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_class == 2'd0) |-> (rsp_latency == LAT_W'(LAT_HIT)));
    a_r5_conflict_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_class == 2'd2) |-> (rsp_latency == LAT_W'(LAT_CONFLICT)));
endmodule

// File: tb/dram_bank_mapper_test.sv
module dram_bank_mapper_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        pre_valid = 1'b0;
    logic [4:0]  pre_bank = '0;
    logic        rsp_valid;
    logic [4:0]  rsp_bank;
    logic [15:0] rsp_row;
    logic [10:0] rsp_col;
    logic [1:0]  rsp_class;
    logic [3:0]  rsp_latency;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    bit         m_open [32];
    logic [15:0] m_row [32];

    always #10 clk = ~clk;

    dram_bank_mapper uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .pre_valid(pre_valid), .pre_bank(pre_bank), .rsp_valid(rsp_valid),
        .rsp_bank(rsp_bank), .rsp_row(rsp_row), .rsp_col(rsp_col),
        .rsp_class(rsp_class), .rsp_latency(rsp_latency)
    );

    function automatic logic [4:0] ref_bank(input logic [31:0] a);
        return a[15:11] ^ a[20:16];
    endfunction

    function automatic logic [3:0] ref_lat(input logic [1:0] c);
        return (c == 2'd0) ? 4'd4 : (c == 2'd1) ? 4'd8 : 4'd14;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the response
    task automatic step(input bit av, input logic [31:0] a, input bit pv, input logic [4:0] pb);
        logic [4:0]  eb;
        logic [15:0] er;
        logic [1:0]  ec;
        eb = ref_bank(a);
        er = a[31:16];
        ec = !m_open[eb] ? 2'd1 : (m_row[eb] == er) ? 2'd0 : 2'd2;
        req_valid = av; req_addr = a; pre_valid = pv; pre_bank = pb;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; pre_valid = 1'b0;
        if (pv && !(av && pb == eb)) m_open[pb] = 1'b0;
        if (av) begin
            m_open[eb] = 1'b1;
            m_row[eb]  = er;
            chk(rsp_valid == 1'b1, "R2 valid", 32'(rsp_valid), 32'd1);
            chk(rsp_bank == eb, "R1 bank", 32'(rsp_bank), 32'(eb));
            chk(rsp_row == er && rsp_col == a[10:0], "R1 row/col",
                {rsp_row, 5'd0, rsp_col}, {er, 5'd0, a[10:0]});
            chk(rsp_class == ec, "R5 class", 32'(rsp_class), 32'(ec));
            chk(rsp_latency == ref_lat(ec), "R5 latency", 32'(rsp_latency), 32'(ref_lat(ec)));
        end else begin
            chk(rsp_valid == 1'b0, "R2 idle", 32'(rsp_valid), 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt [32];
        logic [4:0] b1;
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) begin m_open[i] = 0; m_row[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(rsp_valid == 1'b0, "R8 reset valid", 32'(rsp_valid), 32'd0);

        // R8: first touch of a bank after reset is class 1
        step(1, 32'h0003_2a10, 0, 0);
        chk(rsp_class == 2'd1, "R8 first access closed", 32'(rsp_class), 32'd1);
        // R6: same row again hits
        step(1, 32'h0003_2b44, 0, 0);
        chk(rsp_class == 2'd0, "R6 reopen hit", 32'(rsp_class), 32'd0);
        step(0, 0, 0, 0);

        // R3: same page, different offsets
        step(1, 32'h0012_3800, 0, 0);
        b1 = rsp_bank;
        step(1, 32'h0012_3fff, 0, 0);
        chk(rsp_bank == b1, "R3 same page bank", 32'(rsp_bank), 32'(b1));

        // R4: same set index, tag low bit differs
        step(1, 32'h0040_5840, 0, 0);
        b1 = rsp_bank;
        step(1, 32'h0041_5840, 0, 0);
        chk(rsp_bank != b1, "R4 conflict spread", 32'(rsp_bank), 32'(b1 ^ 5'd1));

        // R7: precharge closes, second precharge harmless
        step(1, 32'h0007_0000, 0, 0);
        b1 = ref_bank(32'h0007_0000);
        step(0, 0, 1, b1);
        step(0, 0, 1, b1);
        step(1, 32'h0007_0000, 0, 0);
        chk(rsp_class == 2'd1, "R7 after precharge", 32'(rsp_class), 32'd1);

        // R9: access and precharge collide on one bank
        step(1, 32'h0008_0000, 1, ref_bank(32'h0008_0000));
        step(1, 32'h0008_0000, 0, 0);
        chk(rsp_class == 2'd0, "R9 access wins", 32'(rsp_class), 32'd0);

        // R10: uniform spread over 1024 consecutive pages
        for (int i = 0; i < 32; i++) cnt[i] = 0;
        for (int p = 0; p < 1024; p++) begin
            step(1, 32'(p) << 11, 0, 0);
            cnt[rsp_bank]++;
        end
        for (int i = 0; i < 32; i++) chk(cnt[i] == 32, "R10 uniform", 32'(cnt[i]), 32'd32);

        // random traffic with few rows so all classes occur
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            bit pv;
            logic [4:0] pb;
            a  = {14'd0, 2'($urandom_range(0, 3)), 16'($urandom)};
            pv = ($urandom_range(0, 4) == 0);
            pb = ($urandom_range(0, 1) == 0) ? ref_bank(a) : 5'($urandom);
            step($urandom_range(0, 7) != 0, a, pv, pb);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule